// File: doc/BRIEF.md
# Four-Mode Effective Address Unit

This block forms operand and jump addresses for a 12-bit single-address machine. Each instruction word carries a 6-bit function code in bits 11:6 and a 6-bit field in bits 5:0. On an accepted start the unit does four things. It reads the field according to a 2-bit mode. It advances the program counter it owns. If the chosen mode needs a pointer word from memory, it fetches it. It then returns either a 12-bit operand or a 12-bit address, with a one-cycle done strobe.

There are four modes. In immediate mode the field itself is the operand, padded with zeros. Direct mode addresses one of the first 64 words. Indirect mode reads a pointer from one of the first 64 words. Relative mode forms an address forward or backward from the instruction's own location. An indirect-jump flag sends the pointer read through the program-relative location instead of the low 64 words. A taken jump loads the final address into the program counter. Decoding the function code and doing arithmetic belong to other blocks.

Top module: `ea_unit`

## Requirements
- R1: After synchronous active-low reset, `pc` is 0 and `done`, `busy` and `mem_req` are 0.
- R2: Mode encoding is 00 immediate, 01 direct, 10 indirect, 11 relative. The field E is `instr[5:0]`. In immediate mode, `result` is E zero-extended to 12 bits, `result_is_data` is 1, and `done` is high in the cycle after the start.
- R3: In direct mode, `result` is E zero-extended, `result_is_data` is 0, and `done` rises in the cycle after start with no memory request.
- R4: In relative mode, `result` is P+E when `rel_back` is 0 and P−E when it is 1, modulo 4096. P is the value of `pc` in the start cycle. `done` follows one cycle after start.
- R5: In indirect mode, `mem_req` rises in the cycle after start with `mem_addr` = E zero-extended. The request and address hold until `mem_ack`. `done` is high in the cycle after the ack, with `result` = `mem_rdata` as sampled at the ack and `result_is_data` = 0.
- R6: In indirect mode with `ind_jump` = 1, the pointer is read from P+E (mod 4096), and `pc` then takes the fetched word in the same cycle as `done`.
- R7: Each accepted start advances `pc` by one, visible the cycle after start, unless a non-indirect jump loads it in that same edge.
- R8: With `jump` = 1 in direct or relative mode, `pc` equals `result` in the `done` cycle. In immediate mode, `jump` and `ind_jump` have no effect on `pc`.
- R9: A start is accepted only while `busy` is 0. While an indirect read is pending, a start changes neither `pc` nor `mem_addr`. `done` falls the cycle after it rises unless another start was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin address formation for `instr` |
| instr | input | 12 | Instruction word: function code 11:6, field E 5:0 |
| mode | input | 2 | Addressing mode (00 imm, 01 direct, 10 indirect, 11 relative) |
| rel_back | input | 1 | Relative direction: 0 forward, 1 backward |
| jump | input | 1 | Instruction is a taken jump |
| ind_jump | input | 1 | Indirect jump through P+E (indirect mode only) |
| busy | output | 1 | Indirect read outstanding; starts ignored |
| pc | output | 12 | Program counter |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 12 | Memory read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 12 | Read data |
| done | output | 1 | Result valid strobe |
| result | output | 12 | Effective address or operand |
| result_is_data | output | 1 | `result` is an immediate operand |

## Verification
The assertions assume that `mem_ack` is only raised while `mem_req` is high. They also assume that `mode`, `rel_back`, `jump` and `ind_jump` are meaningful only in a start cycle. The bench raises the ack only after it has seen the request, after a random delay of zero to five cycles, and holds it for exactly one cycle. Random instruction words, modes, flags and pointer values are mixed with directed cases. The directed cases cover wrap in both relative directions, immediate jumps, and starts issued while a read is pending.

// File: rtl/ea_pkg.sv
// Shared types for the effective address unit.
// Assumes a two-bit mode code fixed by the instruction format.
package ea_pkg;
    typedef enum logic [1:0] {
        MODE_IMM = 2'b00,
        MODE_DIR = 2'b01,
        MODE_IND = 2'b10,
        MODE_REL = 2'b11
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_addr_calc.sv
// Combinational address former: turns mode, field and base P into either
// a final value or a pointer location to be read. Assumes FIELD_W < WORD_W.
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int FIELD_W = 6
) (
    input  ea_mode_e            mode,
    input  logic [FIELD_W-1:0]  field,
    input  logic [WORD_W-1:0]   base_pc,
    input  logic                rel_back,
    input  logic                ind_jump,
    output logic [WORD_W-1:0]   calc_val,
    output logic                calc_is_data,
    output logic                needs_mem,
    output logic [WORD_W-1:0]   mem_ptr
);
    localparam int PAD_W = WORD_W - FIELD_W;

    logic [WORD_W-1:0] ext;
    logic [WORD_W-1:0] fwd;
    logic [WORD_W-1:0] bwd;

    assign ext = {{PAD_W{1'b0}}, field};
    assign fwd = base_pc + ext;
    assign bwd = base_pc - ext;

    // Select the value or pointer that the current mode calls for.
    always_comb begin
        calc_val     = ext;
        calc_is_data = 1'b0;
        needs_mem    = 1'b0;
        mem_ptr      = ext;
        unique case (mode)
            MODE_IMM: calc_is_data = 1'b1;
            MODE_DIR: calc_val     = ext;
            MODE_REL: calc_val     = rel_back ? bwd : fwd;
            MODE_IND: begin
                needs_mem = 1'b1;
                mem_ptr   = ind_jump ? fwd : ext;
            end
            default:  calc_val     = ext;
        endcase
    end
endmodule

// File: rtl/ea_pc_reg.sv
// Program counter: a load takes priority over the start-of-instruction step.
// Assumes load and increment requests come from the fetch controller.
module ea_pc_reg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_val,
    output logic [WORD_W-1:0] pc
);
    logic [WORD_W-1:0] pc_q;

    // Hold, step or load the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (load_en) pc_q <= load_val;
        else if (inc_en)  pc_q <= pc_q + 1'b1;
    end

    assign pc = pc_q;

    // R8
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> pc == $past(load_val));
endmodule

// File: rtl/ea_fetch_ctl.sv
// Sequencer: accepts starts, runs the indirect read handshake and registers
// the result and done strobe. Assumes mem_ack arrives only while mem_req is high.
module ea_fetch_ctl
    import ea_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              needs_mem,
    input  logic [WORD_W-1:0] mem_ptr,
    input  logic [WORD_W-1:0] calc_val,
    input  logic              calc_is_data,
    input  logic              do_jump,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              accept,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              result_is_data,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_load_val
);
    ea_state_e         state_q;
    logic              req_q;
    logic [WORD_W-1:0] addr_q;
    logic              jump_q;
    logic              done_q;
    logic [WORD_W-1:0] res_q;
    logic              isdata_q;
    logic              ack_hit;

    assign busy    = (state_q == ST_WAIT);
    assign accept  = start && (state_q == ST_IDLE);
    assign ack_hit = (state_q == ST_WAIT) && mem_ack;

    // Sequence a start through the optional read and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            req_q    <= 1'b0;
            addr_q   <= '0;
            jump_q   <= 1'b0;
            done_q   <= 1'b0;
            res_q    <= '0;
            isdata_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (needs_mem) begin
                    state_q <= ST_WAIT;
                    req_q   <= 1'b1;
                    addr_q  <= mem_ptr;
                    jump_q  <= do_jump;
                end else begin
                    done_q   <= 1'b1;
                    res_q    <= calc_val;
                    isdata_q <= calc_is_data;
                end
            end else if (ack_hit) begin
                state_q  <= ST_IDLE;
                req_q    <= 1'b0;
                done_q   <= 1'b1;
                res_q    <= mem_rdata;
                isdata_q <= 1'b0;
            end
        end
    end

    // Ask the counter to load the jump target on completion.
    always_comb begin
        pc_load     = 1'b0;
        pc_load_val = calc_val;
        if (accept && !needs_mem && do_jump) begin
            pc_load = 1'b1;
        end else if (ack_hit && jump_q) begin
            pc_load     = 1'b1;
            pc_load_val = mem_rdata;
        end
    end

    assign mem_req        = req_q;
    assign mem_addr       = addr_q;
    assign done           = done_q;
    assign result         = res_q;
    assign result_is_data = isdata_q;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R5
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (done && result == $past(mem_rdata) && !mem_req));
endmodule

// File: rtl/ea_unit.sv
// Top of the effective address unit: splits the instruction, forms the
// address, drives the indirect read and owns the program counter.
// Assumes decode of the function code happens elsewhere.
module ea_unit
    import ea_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int FIELD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [1:0]        mode,
    input  logic              rel_back,
    input  logic              jump,
    input  logic              ind_jump,
    output logic              busy,
    output logic [WORD_W-1:0] pc,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              result_is_data
);
    localparam int FUNC_W = WORD_W - FIELD_W;

    ea_mode_e          mode_e;
    logic [FIELD_W-1:0] field;
    logic [FUNC_W-1:0]  unused_func;
    logic [WORD_W-1:0] calc_val;
    logic              calc_is_data;
    logic              needs_mem;
    logic [WORD_W-1:0] mem_ptr;
    logic              do_jump;
    logic              accept;
    logic              pc_load;
    logic [WORD_W-1:0] pc_load_val;

    assign mode_e      = ea_mode_e'(mode);
    assign field       = instr[FIELD_W-1:0];
    assign unused_func = instr[WORD_W-1:FIELD_W];

    // A jump is honoured in every mode but immediate.
    assign do_jump = (mode_e != MODE_IMM) &&
                     (jump || (ind_jump && mode_e == MODE_IND));

    ea_addr_calc #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) calc_i (
        .mode(mode_e), .field(field), .base_pc(pc), .rel_back(rel_back),
        .ind_jump(ind_jump), .calc_val(calc_val), .calc_is_data(calc_is_data),
        .needs_mem(needs_mem), .mem_ptr(mem_ptr)
    );

    ea_fetch_ctl #(.WORD_W(WORD_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .needs_mem(needs_mem),
        .mem_ptr(mem_ptr), .calc_val(calc_val), .calc_is_data(calc_is_data),
        .do_jump(do_jump), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .accept(accept), .mem_req(mem_req), .mem_addr(mem_addr),
        .done(done), .result(result), .result_is_data(result_is_data),
        .pc_load(pc_load), .pc_load_val(pc_load_val)
    );

    ea_pc_reg #(.WORD_W(WORD_W)) pc_i (
        .clk(clk), .rst_n(rst_n), .inc_en(accept), .load_en(pc_load),
        .load_val(pc_load_val), .pc(pc)
    );

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (!do_jump || mode_e == MODE_IND)) |=> pc == $past(pc) + 1'b1);
    // R9
    pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(start && !busy) && !(mem_req && mem_ack)) |=> $stable(pc));
    // R3
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode_e != MODE_IND) |=> !mem_req);
endmodule

// File: tb/ea_unit_tb.sv
`timescale 1ns/1ps
module ea_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0;
    logic [1:0]  mode = '0;
    logic        rel_back = 1'b0;
    logic        jump = 1'b0;
    logic        ind_jump = 1'b0;
    logic        busy;
    logic [11:0] pc;
    logic        mem_req;
    logic [11:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [11:0] mem_rdata = '0;
    logic        done;
    logic [11:0] result;
    logic        result_is_data;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [11:0] pc_m = '0;

    always #2.5 clk = ~clk;

    ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mode(mode),
        .rel_back(rel_back), .jump(jump), .ind_jump(ind_jump), .busy(busy),
        .pc(pc), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .result(result),
        .result_is_data(result_is_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected non-memory value from the requirements (R2, R3, R4).
    function automatic logic [11:0] exp_val(input logic [1:0] md, input logic [5:0] e,
                                            input logic bk, input logic [11:0] p);
        logic [11:0] x = {6'b0, e};
        if (md == 2'b11) return bk ? p - x : p + x;
        return x;
    endfunction

    // Issue one instruction and check it end to end.
    task automatic run(input logic [11:0] ins, input logic [1:0] md, input logic bk,
                       input logic jp, input logic ij, input logic [11:0] word,
                       input int dly, input bit poke);
        logic [11:0] p0 = pc_m;
        logic [11:0] ev;
        logic [11:0] ea;
        @(negedge clk);
        instr = ins; mode = md; rel_back = bk; jump = jp; ind_jump = ij; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pc_m = p0 + 12'd1;
        if (md != 2'b10) begin
            ev = exp_val(md, ins[5:0], bk, p0);
            if (jp && md != 2'b00) pc_m = ev;
            chk(done === 1'b1, "R2/R3/R4 done", int'(done), 1);
            chk(result === ev, md == 2'b11 ? "R4 result" : (md == 2'b01 ? "R3 result" : "R2 result"),
                int'(result), int'(ev));
            chk(result_is_data === (md == 2'b00), "R2 is_data", int'(result_is_data), int'(md == 2'b00));
            chk(mem_req === 1'b0, "R3 no request", int'(mem_req), 0);
            chk(pc === pc_m, jp ? "R8 pc" : "R7 pc", int'(pc), int'(pc_m));
        end else begin
            ea = ij ? p0 + {6'b0, ins[5:0]} : {6'b0, ins[5:0]};
            chk(mem_req === 1'b1, "R5 request", int'(mem_req), 1);
            chk(mem_addr === ea, ij ? "R6 pointer addr" : "R5 pointer addr", int'(mem_addr), int'(ea));
            chk(pc === pc_m, "R7 pc at start", int'(pc), int'(pc_m));
            chk(busy === 1'b1, "R9 busy", int'(busy), 1);
            for (int k = 0; k < dly; k++) begin
                if (poke && k == 0) begin
                    instr = ~ins; mode = 2'b11; jump = 1'b1; start = 1'b1;
                end
                @(negedge clk);
                start = 1'b0;
                chk(mem_req === 1'b1 && mem_addr === ea, "R5 hold", int'(mem_addr), int'(ea));
                chk(pc === pc_m, "R9 pc while busy", int'(pc), int'(pc_m));
                chk(done === 1'b0, "R5 no early done", int'(done), 0);
            end
            mem_ack = 1'b1; mem_rdata = word;
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = ~word;
            if (jp || ij) pc_m = word;
            chk(done === 1'b1, "R5 done", int'(done), 1);
            chk(result === word, "R5 result", int'(result), int'(word));
            chk(result_is_data === 1'b0, "R5 is_data", int'(result_is_data), 0);
            chk(mem_req === 1'b0, "R5 request dropped", int'(mem_req), 0);
            chk(pc === pc_m, ij ? "R6 pc" : "R8 pc", int'(pc), int'(pc_m));
        end
        @(negedge clk);
        chk(done === 1'b0, "R9 single done", int'(done), 0);
        chk(pc === pc_m, "R9 pc stable", int'(pc), int'(pc_m));
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk(pc === 12'd0 && done === 1'b0 && busy === 1'b0 && mem_req === 1'b0,
            "R1 reset", int'({pc, done, busy, mem_req}), 0);
        rst_n = 1'b1;
        // Directed corners.
        run(12'o7777, 2'b00, 1'b0, 1'b1, 1'b1, 12'd0, 0, 1'b0); // R2 + R8 imm jump ignored
        run(12'o0177, 2'b01, 1'b0, 1'b0, 1'b0, 12'd0, 0, 1'b0); // R3
        run(12'o0005, 2'b11, 1'b1, 1'b0, 1'b0, 12'd0, 0, 1'b0); // R4 backward wrap
        run(12'o0010, 2'b10, 1'b0, 1'b0, 1'b1, 12'd4090, 3, 1'b1); // R6 + R9 poke
        run(12'o0077, 2'b11, 1'b0, 1'b0, 1'b0, 12'd0, 0, 1'b0); // R4 forward wrap
        run(12'o0003, 2'b11, 1'b0, 1'b1, 1'b0, 12'd0, 0, 1'b0); // R8 relative jump
        run(12'o0041, 2'b10, 1'b0, 1'b0, 1'b0, 12'd1234, 0, 1'b0); // R5 zero delay
        for (int n = 0; n < 400; n++) begin
            run(12'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                12'($urandom), int'($urandom_range(0, 5)), 1'($urandom));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule